// File: doc/BRIEF.md
# Chained XOR and Copy Descriptor Engine

This block is one DMA channel that processes a linked list of descriptors stored in memory. Each descriptor names a destination buffer, a byte count and up to eight source buffers. The engine reads one 32-bit word from every source that is taking part, combines those words by bitwise XOR and writes the result to the destination. It repeats this word by word until the byte count is used up. A copy is the same data path with only source 0 taking part. When a descriptor is complete, the engine marks it as successful in memory and then follows the descriptor's link. A link of zero ends the chain.

Software loads the address of the first descriptor into a next-descriptor register and sets the start bit in the activation register. While the chain runs, software can read which descriptor is current and whether the channel is busy. It can also wait for the two event pulses: one for a finished descriptor and one for a finished chain. Memory is reached through a simple word-wide port that has a fixed read latency of one cycle.

Top module: `xor_chain_engine`

## Requirements
- R1: After reset, all four registers read zero, the channel state field reads 0 (idle), no memory request is made and neither event pulses.
- R2: Writing a word with bit 0 set to register 2 (activation) while idle starts the channel at the byte address held in register 0 (next descriptor). Register 1 (current descriptor) then reads that address. Register 2 bits [5:4] read 1 while the channel runs and 0 once it is idle. Descriptor layout in 32-bit words from its base: word 0 status, 1 command, 2 link, 3 destination, 4 byte count, 5 to 12 the addresses of sources 0 to 7.
- R3: In XOR operation, bit i (i = 0..7) of the command word enables source i. Each destination word is the XOR of the same word offset of every enabled source. Disabled sources have no effect on the result.
- R4: In copy operation (operation code 2), the destination receives source 0 only, whatever the enable bits say.
- R5: When register 3 (configuration) bit 3 is 1, the operation code comes from command bits [26:24]; when it is 0, the code comes from configuration bits [2:0]. Code 2 means copy and any other code means XOR.
- R6: Exactly byte count / 4 consecutive destination words are written, and the word after them is left untouched. A count of 4 bytes writes a single word.
- R7: On finishing a descriptor, the engine writes 0x80000000 (success in bit 31) to that descriptor's status word before it moves to the link.
- R8: One end-of-descriptor pulse is produced for each finished descriptor whose command bit 31 is set, and none for a descriptor with that bit clear.
- R9: The engine follows links through the chain until it reaches a link of zero. At that point it produces one end-of-chain pulse, returns to idle, and register 1 holds the address of the last descriptor.
- R10: A start written while the channel is busy is ignored: the running chain is unaffected and no other descriptor is processed.
- R11: When configuration bit 4 is 1, every descriptor word read, and the status word written back, is byte-reversed. Buffer data is never reversed.
- R12: After a chain ends, rewriting register 0 and starting again runs a new chain from the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index: 0 next, 1 current, 2 activation, 3 configuration |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_addr | output | 32 | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid one cycle after a read request |
| eod_evt | output | 1 | One-cycle end-of-descriptor pulse |
| eoc_evt | output | 1 | One-cycle end-of-chain pulse |

## Verification
The bench uses a sparse enable pattern across all eight sources. A design that indexed the bitmap wrongly, or stopped after the first disabled source, would produce wrong destination words. It runs a copy while several enable bits are set, and a register-selected operation that contradicts the descriptor field; mixing up the operation source would give the XOR of several buffers where a copy was expected. It probes the one-word count and the guard word after each buffer, which catches a loop that runs one word too many or too few. It also checks the cases where a design would misbehave around starting and stopping: a three-descriptor chain with mixed interrupt enables, a start written while busy (which would make a careless design jump into another chain), a restart after the chain ends, and byte-reversed descriptors, whose status word would come back in the wrong byte order if the reversal were missed on write-back.

// File: rtl/xor_chain_engine.sv
module xor_chain_engine #(
  parameter int NSRC = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  output logic        eod_evt,
  output logic        eoc_evt
);
  localparam int KLAST = 4 + NSRC;
  localparam int KW = $clog2(KLAST + 1);
  localparam int IW = $clog2(NSRC + 1);
  localparam int SW = $clog2(NSRC);
  localparam logic [2:0] OP_COPY = 3'd2;
  localparam logic [31:0] OK_WORD = 32'h8000_0000;

  typedef enum logic [2:0] {S_IDLE, S_DRQ, S_DCAP, S_SRQ, S_SCAP, S_WR, S_STAT} st_t;

  st_t st;
  logic [31:0] next_q, cur_q, cmd_q, nxt_q, dst_q, cnt_q, acc;
  logic [4:0] cfg_q;
  logic [31:0] src_a [NSRC];
  logic [KW-1:0] k;
  logic [IW-1:0] i;
  logic [29:0] w;

  function automatic logic [31:0] bswap(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  logic busy, act_wr, src_hit, last_word;
  logic [2:0] opsel;
  logic [NSRC-1:0] mask;
  logic [31:0] fld;
  logic [SW-1:0] sidx;

  assign busy = (st != S_IDLE);
  assign act_wr = reg_we && (reg_addr == 2'd2) && reg_wdata[0];
  assign opsel = cfg_q[3] ? cmd_q[26:24] : cfg_q[2:0];
  assign mask = (opsel == OP_COPY) ? NSRC'(1) : cmd_q[NSRC-1:0];
  assign fld = cfg_q[4] ? bswap(mem_rdata) : mem_rdata;
  assign sidx = i[SW-1:0];
  assign src_hit = (i < IW'(NSRC)) && mask[sidx];
  assign last_word = (w + 30'd1) == cnt_q[31:2];

  assign mem_req = (st == S_DRQ) || (st == S_SRQ && src_hit) || (st == S_WR) || (st == S_STAT);
  assign mem_we = (st == S_WR) || (st == S_STAT);
  assign mem_wdata = (st == S_STAT) ? (cfg_q[4] ? bswap(OK_WORD) : OK_WORD) : acc;

  always_comb begin
    case (st)
      S_DRQ:   mem_addr = cur_q + 32'({k, 2'b00});
      S_SRQ:   mem_addr = src_a[sidx] + {w, 2'b00};
      S_WR:    mem_addr = dst_q + {w, 2'b00};
      default: mem_addr = cur_q;
    endcase
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = next_q;
      2'd1:    reg_rdata = cur_q;
      2'd2:    reg_rdata = {26'd0, 1'b0, busy, 4'd0};
      default: reg_rdata = {27'd0, cfg_q};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      next_q <= '0;
      cur_q <= '0;
      cfg_q <= '0;
      cmd_q <= '0;
      nxt_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
      acc <= '0;
      k <= '0;
      i <= '0;
      w <= '0;
      eod_evt <= 1'b0;
      eoc_evt <= 1'b0;
      for (int j = 0; j < NSRC; j++) src_a[j] <= '0;
    end else begin
      eod_evt <= 1'b0;
      eoc_evt <= 1'b0;
      if (reg_we && reg_addr == 2'd0) next_q <= reg_wdata;
      if (reg_we && reg_addr == 2'd3) cfg_q <= reg_wdata[4:0];
      case (st)
        S_IDLE: if (act_wr) begin
          cur_q <= next_q;
          k <= KW'(1);
          st <= S_DRQ;
        end
        S_DRQ: st <= S_DCAP;
        S_DCAP: begin
          if (k == KW'(1)) cmd_q <= fld;
          if (k == KW'(2)) nxt_q <= fld;
          if (k == KW'(3)) dst_q <= fld;
          if (k == KW'(4)) cnt_q <= fld;
          for (int j = 0; j < NSRC; j++)
            if (k == KW'(5 + j)) src_a[j] <= fld;
          if (k == KW'(KLAST)) begin
            i <= '0;
            w <= '0;
            acc <= '0;
            st <= S_SRQ;
          end else begin
            k <= k + KW'(1);
            st <= S_DRQ;
          end
        end
        S_SRQ: begin
          if (i >= IW'(NSRC)) st <= S_WR;
          else if (src_hit) st <= S_SCAP;
          else i <= i + IW'(1);
        end
        S_SCAP: begin
          acc <= acc ^ mem_rdata;
          i <= i + IW'(1);
          st <= S_SRQ;
        end
        S_WR: begin
          if (last_word) st <= S_STAT;
          else begin
            w <= w + 30'd1;
            i <= '0;
            acc <= '0;
            st <= S_SRQ;
          end
        end
        S_STAT: begin
          eod_evt <= cmd_q[31];
          if (nxt_q == 32'd0) begin
            eoc_evt <= 1'b1;
            st <= S_IDLE;
          end else begin
            cur_q <= nxt_q;
            k <= KW'(1);
            st <= S_DRQ;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_mem_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  assert_start_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (cur_q == $past(next_q)));

  assert_eod_after_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eod_evt |-> ($past(mem_we) && $past(mem_addr) == $past(cur_q)));

  assert_eoc_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_evt |-> !busy);

  assert_busy_kick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && act_wr && st != S_STAT) |=> $stable(cur_q));
endmodule

// File: tb/tb_xor_chain_engine.sv
`timescale 1ns/1ps
module tb_xor_chain_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = 32'd0;
  logic eod_evt, eoc_evt;

  always #10 clk = ~clk;

  xor_chain_engine dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .eod_evt(eod_evt), .eoc_evt(eoc_evt));

  logic [31:0] mem [1024];
  logic tb_we = 1'b0;
  logic [31:0] tb_a = 32'd0, tb_d = 32'd0;
  int eod_n = 0, eoc_n = 0;
  int nchk = 0, nfail = 0;

  always @(posedge clk) begin
    if (tb_we) mem[tb_a[11:2]] <= tb_d;
    else if (mem_req) begin
      if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
      else mem_rdata <= mem[mem_addr[11:2]];
    end
    if (eod_evt) eod_n <= eod_n + 1;
    if (eoc_evt) eoc_n <= eoc_n + 1;
  end

  function automatic logic [31:0] bsw(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  function automatic logic [31:0] srcaddr(input int s, input int wd);
    return 32'(32'h800 + s * 32'h40 + wd * 4);
  endfunction

  function automatic logic [31:0] srcval(input int s, input int wd);
    return 32'((s + 1) * 32'h0103_0507) ^ 32'(wd * 32'h1020_4081) ^ 32'hA5A5_0000;
  endfunction

  function automatic logic [31:0] exp_xor(input logic [7:0] m, input int wd);
    logic [31:0] a = 32'd0;
    for (int s = 0; s < 8; s++) if (m[s]) a = a ^ srcval(s, wd);
    return a;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); tb_we = 1'b1; tb_a = a; tb_d = d;
    @(posedge clk); #1 tb_we = 1'b0;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] mkcmd(input bit eod, input logic [2:0] op, input logic [7:0] m);
    return {eod, 4'd0, op, 16'd0, m};
  endfunction

  task automatic mk_desc(input logic [31:0] b, input logic [31:0] cmd, input logic [31:0] nx,
                         input logic [31:0] ds, input logic [31:0] cnt, input bit sw);
    logic [31:0] f [13];
    f[0] = 32'd0; f[1] = cmd; f[2] = nx; f[3] = ds; f[4] = cnt;
    for (int s = 0; s < 8; s++) f[5+s] = srcaddr(s, 0);
    for (int j = 0; j < 13; j++) poke(b + 32'(j*4), sw ? bsw(f[j]) : f[j]);
  endtask

  task automatic preset_dest(input logic [31:0] ds, input int nw);
    for (int j = 0; j <= nw; j++) poke(ds + 32'(j*4), 32'hDEAD_BEEF);
  endtask

  task automatic chk_dest(input string tag, input logic [31:0] ds, input logic [7:0] m, input int nw);
    for (int j = 0; j < nw; j++) chk(tag, mem[ds[11:2] + 10'(j)], exp_xor(m, j));
  endtask

  task automatic run_wait();
    int e0 = eoc_n;
    int n = 0;
    while (eoc_n == e0 && n < 20000) begin @(negedge clk); n++; end
    if (eoc_n == e0) begin nfail++; nchk++; $display("FAIL R9 chain never ended actual=0 expected=1"); end
    repeat (3) @(negedge clk);
  endtask

  task automatic kick(input logic [31:0] b);
    wr_reg(2'd0, b);
    wr_reg(2'd2, 32'd1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 4; a++) begin rd_reg(2'(a), d); chk("R1 register reset", d, 32'd0); end
    chk("R1 no request", {31'd0, mem_req}, 32'd0);
    chk("R1 no events", {30'd0, eod_evt, eoc_evt}, 32'd0);
  endtask

  task automatic t_basic();
    logic [31:0] d;
    int e0 = eod_n, c0 = eoc_n;
    wr_reg(2'd3, 32'h8);
    mk_desc(32'h100, mkcmd(1, 3'd1, 8'h0F), 32'd0, 32'hC00, 32'd16, 0);
    preset_dest(32'hC00, 4);
    kick(32'h100);
    rd_reg(2'd2, d); chk("R2 busy state", d, 32'h10);
    run_wait();
    chk_dest("R3 four sources", 32'hC00, 8'h0F, 4);
    chk("R6 guard word", mem[10'h300 + 10'd4], 32'hDEAD_BEEF);
    chk("R7 status", mem[10'h040], 32'h8000_0000);
    chk("R8 eod count", 32'(eod_n - e0), 32'd1);
    chk("R9 eoc count", 32'(eoc_n - c0), 32'd1);
    rd_reg(2'd1, d); chk("R2 current", d, 32'h100);
    rd_reg(2'd2, d); chk("R2 idle state", d, 32'h0);
  endtask

  task automatic t_sparse();
    int e0 = eod_n;
    mk_desc(32'h100, mkcmd(0, 3'd1, 8'hA5), 32'd0, 32'hC00, 32'd12, 0);
    preset_dest(32'hC00, 3);
    kick(32'h100);
    run_wait();
    chk_dest("R3 sparse eight", 32'hC00, 8'hA5, 3);
    chk("R8 no eod when disabled", 32'(eod_n - e0), 32'd0);
  endtask

  task automatic t_copy();
    mk_desc(32'h100, mkcmd(0, 3'd2, 8'h0F), 32'd0, 32'hC00, 32'd4, 0);
    preset_dest(32'hC00, 1);
    kick(32'h100);
    run_wait();
    chk("R4 copy source 0", mem[10'h300], srcval(0, 0));
    chk("R6 one word guard", mem[10'h301], 32'hDEAD_BEEF);
  endtask

  task automatic t_opsel();
    wr_reg(2'd3, 32'h2);
    mk_desc(32'h100, mkcmd(0, 3'd1, 8'h06), 32'd0, 32'hC00, 32'd8, 0);
    preset_dest(32'hC00, 2);
    kick(32'h100);
    run_wait();
    chk_dest("R5 register copy", 32'hC00, 8'h01, 2);
    wr_reg(2'd3, 32'h1);
    mk_desc(32'h100, mkcmd(0, 3'd2, 8'h06), 32'd0, 32'hC00, 32'd8, 0);
    preset_dest(32'hC00, 2);
    kick(32'h100);
    run_wait();
    chk_dest("R5 register xor", 32'hC00, 8'h06, 2);
    wr_reg(2'd3, 32'h8);
  endtask

  task automatic t_chain();
    logic [31:0] d;
    int e0 = eod_n, c0 = eoc_n;
    mk_desc(32'h100, mkcmd(1, 3'd1, 8'h03), 32'h140, 32'hC00, 32'd8, 0);
    mk_desc(32'h140, mkcmd(0, 3'd1, 8'h30), 32'h180, 32'hC40, 32'd8, 0);
    mk_desc(32'h180, mkcmd(1, 3'd1, 8'hC1), 32'd0, 32'hC80, 32'd8, 0);
    preset_dest(32'hC00, 2); preset_dest(32'hC40, 2); preset_dest(32'hC80, 2);
    kick(32'h100);
    run_wait();
    chk_dest("R9 chain first", 32'hC00, 8'h03, 2);
    chk_dest("R9 chain second", 32'hC40, 8'h30, 2);
    chk_dest("R9 chain third", 32'hC80, 8'hC1, 2);
    chk("R7 chain status a", mem[10'h040], 32'h8000_0000);
    chk("R7 chain status b", mem[10'h050], 32'h8000_0000);
    chk("R7 chain status c", mem[10'h060], 32'h8000_0000);
    chk("R8 mixed eod", 32'(eod_n - e0), 32'd2);
    chk("R9 single eoc", 32'(eoc_n - c0), 32'd1);
    rd_reg(2'd1, d); chk("R9 last current", d, 32'h180);
  endtask

  task automatic t_busy_kick();
    logic [31:0] d;
    int c0 = eoc_n;
    mk_desc(32'h100, mkcmd(0, 3'd1, 8'hFF), 32'd0, 32'hC00, 32'd64, 0);
    mk_desc(32'h200, mkcmd(0, 3'd1, 8'h11), 32'd0, 32'hD00, 32'd8, 0);
    preset_dest(32'hD00, 2);
    kick(32'h100);
    repeat (40) @(negedge clk);
    wr_reg(2'd0, 32'h200);
    wr_reg(2'd2, 32'd1);
    run_wait();
    chk_dest("R10 running chain intact", 32'hC00, 8'hFF, 16);
    chk("R10 other status untouched", mem[10'h080], 32'd0);
    chk("R10 other dest untouched", mem[10'h340], 32'hDEAD_BEEF);
    chk("R10 one eoc", 32'(eoc_n - c0), 32'd1);
    rd_reg(2'd1, d); chk("R10 current kept", d, 32'h100);
    wr_reg(2'd2, 32'd1);
    run_wait();
    chk_dest("R12 restart dest", 32'hD00, 8'h11, 2);
    chk("R12 restart status", mem[10'h080], 32'h8000_0000);
    rd_reg(2'd1, d); chk("R12 restart current", d, 32'h200);
  endtask

  task automatic t_swap();
    wr_reg(2'd3, 32'h18);
    mk_desc(32'h100, mkcmd(1, 3'd1, 8'h81), 32'd0, 32'hC00, 32'd8, 1);
    preset_dest(32'hC00, 2);
    kick(32'h100);
    run_wait();
    chk_dest("R11 swapped data", 32'hC00, 8'h81, 2);
    chk("R11 swapped status", mem[10'h040], 32'h0000_0080);
    wr_reg(2'd3, 32'h8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++; nchk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    for (int s = 0; s < 8; s++)
      for (int j = 0; j < 16; j++) poke(srcaddr(s, j), srcval(s, j));
    t_basic();
    t_sparse();
    t_copy();
    t_opsel();
    t_chain();
    t_busy_kick();
    t_swap();
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule